// File: doc/BRIEF.md
# System configuration register controller

This block is a 32-bit register file in a 4 KB address window, reached over a simple synchronous bus. The bus carries a select, a write enable, a 12-bit byte offset, write data and read data. It holds two general read/write configuration words. The low eight bits of the second word drive eight LED outputs. It also holds read-only identification words fixed by parameters.

A clock-lock status word combines a writable 8-bit lock mask with eight per-loop locked flags taken from an input port. Its bit 0 is a summary: it is 1 when every loop selected by the mask reports locked.

An indirect configuration channel reaches a small bank of oscillator-frequency registers. Software first puts a value in the out-data register. It then writes the control register with a device index, a function code, a direction flag and a start bit. The transaction completes at the clock edge that takes the control write.

The channel's status is held in a three-state machine:

- CH_IDLE: status 0.
- CH_DONE: status 1, done.
- CH_FAULT: status 3, done and error.

Every control write moves the machine:

- to CH_IDLE when the start bit is 0;
- to CH_DONE when the start bit is 1 and the request is valid;
- to CH_FAULT when the start bit is 1 and the request is invalid.

With no control write, the machine holds its state.

Top module: `syscfg_regs`

## Requirements
- R1: After reset:
  - the control register reads 0x0010_0000;
  - the lock word reads 0xFFFF_0001 while the locked-flag input is 0xFF;
  - the two configuration words, both data registers and status read 0;
  - the LED outputs are 0.
- R2: The configuration words at 0x000 and 0x004 and the out-data register at 0x0A4 store all 32 written bits and read them back. Bits [7:0] of the word at 0x004 drive the LED outputs from the cycle after the write.
- R3: Writes to the read-only words have no effect:
  - 0x00C always reads 0;
  - 0x010, 0xFF8 and 0xFFC read their parameter values.
- R4: A read from an unmapped offset returns 0, and a write to one changes no register. In the cycle after any unmapped access, the error output is 1 for one cycle. It is 0 after a mapped access.
- R5: The control register at 0x0A8 has these fields:
  - device index: bits [11:0];
  - function code: bits [25:20];
  - direction flag: bit 30, where 1 means write;
  - start: bit 31.

  The first three fields are stored. Bits [19:12], [29:26] and 31 always read as 0.
- R6: Any control write clears the status register at 0x0AC. When the written start bit is 1, status bit 0 (done) is 1 from the next cycle.
- R7: A request is valid only if the function code is 1 and the device index is below 3. An invalid start sets status to 3 (bit 1 error, bit 0 done). It changes no oscillator register and leaves the return-data register unchanged.
- R8: A valid write start copies the out-data register into the indexed oscillator register. A valid read start loads the indexed oscillator register into the return-data register at 0x0A0.
- R9: The oscillator registers 0, 1 and 2 reset to parameter values. The defaults are 50,000,000, 24,576,000 and 25,000,000.
- R10: The lock word at 0x100 is laid out as follows:
  - bits [31:24] are the mask, the only writable bits;
  - bits [23:16] mirror the locked-flag input;
  - bits [15:1] read 0;
  - bit 0 is 1 exactly when every flag whose mask bit is 1 is set, and is therefore 1 for a zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read, 0 otherwise |
| bus_err | output | 1 | One-cycle flag after an unmapped access |
| loop_locked | input | 8 | Per-loop locked flags |
| led | output | 8 | LED drive from configuration word 1 |

## Verification
The channel is driven with several kinds of request:

- valid write and read starts on each device index, which show that the right oscillator register is reached and that reset values are distinct per index;
- a device index of 3 and function codes 2 and 63, which separate the bounds check from the function check;
- a control write with start clear, which shows the status clear apart from a start.

An all-ones control write shows that reserved bits are masked but stored fields are kept. The lock summary is tried with masks of zero, a partial mask with a masked-out flag low, and an unmasked flag low. This tells the masked AND from a plain AND or OR of the flags.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_CFG0 = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG1 = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CFG3 = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_CFG4 = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_RET  = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFF_OUT  = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFF_STAT = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFF_LOCK = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_AID  = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFF_ID   = 12'hFFC;

    localparam int DEV_W  = 12;
    localparam int FUNC_W = 6;

    // Encoding doubles as the status word: {error, done}
    typedef enum logic [1:0] {
        CH_IDLE  = 2'b00,
        CH_DONE  = 2'b01,
        CH_FAULT = 2'b11
    } chan_state_e;

    typedef struct packed {
        logic              wr;
        logic [FUNC_W-1:0] func;
        logic [DEV_W-1:0]  dev;
    } ctrl_t;

endpackage

// File: rtl/syscfg_osc_bank.sv
module syscfg_osc_bank #(
    parameter int NUM_OSC = 3,
    parameter int IDX_W = 2,
    parameter logic [NUM_OSC-1:0][31:0] RESET_VALS = {32'd25000000, 32'd24576000, 32'd50000000}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0] osc_q [NUM_OSC];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                osc_q[g] <= RESET_VALS[g];
            end else if (we && (int'(idx) == g)) begin
                osc_q[g] <= wdata;
            end
        end

        // R7: an entry not addressed by a write strobe keeps its value
        p_osc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (int'(idx) == g)) |=> $stable(osc_q[g]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (int'(idx) == i) begin
                rdata = osc_q[i];
            end
        end
    end

endmodule

// File: rtl/syscfg_cfg_channel.sv
module syscfg_cfg_channel
    import syscfg_pkg::*;
#(
    parameter int NUM_OSC = 3,
    parameter int IDX_W = 2,
    parameter int TARGET_FUNC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              req_start,
    input  logic              req_wr,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [31:0]       osc_rdata,
    output logic              osc_we,
    output logic [IDX_W-1:0]  osc_idx,
    output logic [31:0]       ctrl_rd,
    output logic [31:0]       ret_rd,
    output logic [1:0]        status
);

    chan_state_e state_q, state_d;
    ctrl_t       ctrl_q;
    logic [31:0] ret_q;
    logic        req_ok;
    logic        ret_load;

    assign req_ok = (req_func == FUNC_W'(TARGET_FUNC)) && (req_dev < DEV_W'(NUM_OSC));

    always_comb begin
        state_d = state_q;
        unique casez ({ctrl_we, req_start, req_ok})
            3'b0??: state_d = state_q;
            3'b10?: state_d = CH_IDLE;
            3'b110: state_d = CH_FAULT;
            3'b111: state_d = CH_DONE;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        osc_we   = ctrl_we && req_start && req_ok && req_wr;
        ret_load = ctrl_we && req_start && req_ok && !req_wr;
        osc_idx  = req_dev[IDX_W-1:0];
        status   = state_q;
        ctrl_rd  = {1'b0, ctrl_q.wr, 4'b0, ctrl_q.func, 8'b0, ctrl_q.dev};
        ret_rd   = ret_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{wr: 1'b0, func: FUNC_W'(1), dev: '0};
            ret_q  <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= '{wr: req_wr, func: req_func, dev: req_dev};
            end
            if (ret_load) begin
                ret_q <= osc_rdata;
            end
        end
    end

    // R6: a control write without start leaves status clear
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !req_start) |=> (status == 2'b00));

    // R6: a start always reports done
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && req_start) |=> status[0]);

    // R7: a bad function or device reports error with done
    p_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && req_start && ((req_func != FUNC_W'(TARGET_FUNC)) || (req_dev >= DEV_W'(NUM_OSC))))
        |=> (status == 2'b11));

    // R6: status only moves on a control write
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(status));

    // R8: return data only changes on a valid read start
    p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_we && req_start && !req_wr) |=> $stable(ret_rd));

endmodule

// File: rtl/syscfg_lock.sv
module syscfg_lock #(
    parameter int NUM_LOOPS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [NUM_LOOPS-1:0] wmask,
    input  logic [NUM_LOOPS-1:0] locked,
    output logic [31:0]          lock_word
);

    localparam int PAD_W = 32 - 2 * NUM_LOOPS - 1;

    logic [NUM_LOOPS-1:0] mask_q;
    logic                 summary;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (we) begin
            mask_q <= wmask;
        end
    end

    assign summary   = &(locked | ~mask_q);
    assign lock_word = {mask_q, locked, {PAD_W{1'b0}}, summary};

    // R10: an empty mask always reports all locked
    p_mask_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> summary);

    // R10: the mask changes only through a lock-word write
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mask_q));

    // R10: all flags set means locked regardless of mask
    p_all_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&locked) |-> summary);

endmodule

// File: rtl/syscfg_regs.sv
module syscfg_regs
    import syscfg_pkg::*;
#(
    parameter logic [31:0] CFG4_VALUE = 32'h0,
    parameter logic [31:0] AID_VALUE = 32'h0,
    parameter logic [31:0] ID_VALUE = 32'h0,
    parameter int NUM_OSC = 3,
    parameter logic [NUM_OSC-1:0][31:0] OSC_RESET = {32'd25000000, 32'd24576000, 32'd50000000},
    parameter int LED_W = 8,
    parameter int NUM_LOOPS = 8,
    parameter bit HAS_ERR_FLAG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    input  logic [NUM_LOOPS-1:0] loop_locked,
    output logic [LED_W-1:0]     led
);

    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

    logic        rd_en, wr_en, mapped;
    logic [31:0] cfg0_q, cfg1_q, out_q;
    logic [31:0] ctrl_rd, ret_rd, lock_word, osc_rdata;
    logic [1:0]  status;
    logic        osc_we;
    logic [IDX_W-1:0] osc_idx;

    assign rd_en = bus_sel && !bus_write;
    assign wr_en = bus_sel && bus_write;

    always_comb begin
        mapped = 1'b1;
        case (bus_addr)
            OFF_CFG0, OFF_CFG1, OFF_CFG3, OFF_CFG4, OFF_RET, OFF_OUT,
            OFF_CTRL, OFF_STAT, OFF_LOCK, OFF_AID, OFF_ID: mapped = 1'b1;
            default: mapped = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0_q <= '0;
            cfg1_q <= '0;
            out_q  <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFF_CFG0) cfg0_q <= bus_wdata;
            if (bus_addr == OFF_CFG1) cfg1_q <= bus_wdata;
            if (bus_addr == OFF_OUT)  out_q  <= bus_wdata;
        end
    end

    assign led = cfg1_q[LED_W-1:0];

    syscfg_cfg_channel #(
        .NUM_OSC(NUM_OSC),
        .IDX_W(IDX_W),
        .TARGET_FUNC(1)
    ) u_channel (
        .clk(clk),
        .rst_n(rst_n),
        .ctrl_we(wr_en && (bus_addr == OFF_CTRL)),
        .req_start(bus_wdata[31]),
        .req_wr(bus_wdata[30]),
        .req_func(bus_wdata[25:20]),
        .req_dev(bus_wdata[11:0]),
        .osc_rdata(osc_rdata),
        .osc_we(osc_we),
        .osc_idx(osc_idx),
        .ctrl_rd(ctrl_rd),
        .ret_rd(ret_rd),
        .status(status)
    );

    syscfg_osc_bank #(
        .NUM_OSC(NUM_OSC),
        .IDX_W(IDX_W),
        .RESET_VALS(OSC_RESET)
    ) u_osc (
        .clk(clk),
        .rst_n(rst_n),
        .we(osc_we),
        .idx(osc_idx),
        .wdata(out_q),
        .rdata(osc_rdata)
    );

    syscfg_lock #(
        .NUM_LOOPS(NUM_LOOPS)
    ) u_lock (
        .clk(clk),
        .rst_n(rst_n),
        .we(wr_en && (bus_addr == OFF_LOCK)),
        .wmask(bus_wdata[31:32-NUM_LOOPS]),
        .locked(loop_locked),
        .lock_word(lock_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFF_CFG0: bus_rdata = cfg0_q;
                OFF_CFG1: bus_rdata = cfg1_q;
                OFF_CFG3: bus_rdata = '0;
                OFF_CFG4: bus_rdata = CFG4_VALUE;
                OFF_RET:  bus_rdata = ret_rd;
                OFF_OUT:  bus_rdata = out_q;
                OFF_CTRL: bus_rdata = ctrl_rd;
                OFF_STAT: bus_rdata = {30'b0, status};
                OFF_LOCK: bus_rdata = lock_word;
                OFF_AID:  bus_rdata = AID_VALUE;
                OFF_ID:   bus_rdata = ID_VALUE;
                default:  bus_rdata = '0;
            endcase
        end
    end

    if (HAS_ERR_FLAG) begin : g_err
        logic err_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_q <= 1'b0;
            end else begin
                err_q <= bus_sel && !mapped;
            end
        end

        assign bus_err = err_q;

        // R4: every unmapped access raises the flag next cycle
        p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !mapped) |=> bus_err);

        // R4: no flag after an idle cycle or a mapped access
        p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && !mapped) |=> !bus_err);
    end else begin : g_no_err
        assign bus_err = 1'b0;
    end

    // R5: reserved and start positions of the control word read zero
    p_ctrl_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr == OFF_CTRL)) |-> (bus_rdata[31] == 1'b0 &&
        bus_rdata[29:26] == 4'b0 && bus_rdata[19:12] == 8'b0));

    // R2: the LEDs follow a configuration word 1 write
    p_led_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bus_addr == OFF_CFG1)) |=> (led == $past(bus_wdata[LED_W-1:0])));

    // R3: configuration word 3 never reads anything but zero
    p_cfg3_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr == OFF_CFG3)) |-> (bus_rdata == '0));

endmodule

// File: tb/syscfg_regs_bench.sv
`timescale 1ns/1ps
module syscfg_regs_bench;

    localparam logic [31:0] B_CFG4 = 32'h0000_0A5C;
    localparam logic [31:0] B_AID  = 32'hB001_0203;
    localparam logic [31:0] B_ID   = 32'h4100_0385;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  loop_locked = 8'hFF;
    logic [7:0]  led;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    syscfg_regs #(
        .CFG4_VALUE(B_CFG4),
        .AID_VALUE(B_AID),
        .ID_VALUE(B_ID)
    ) u_syscfg_regs (
        .clk(clk),
        .rst_n(rst_n),
        .bus_sel(bus_sel),
        .bus_write(bus_write),
        .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_err(bus_err),
        .loop_locked(loop_locked),
        .led(led)
    );

    // Row: {write, offset, data (write value or expected read), requirement code}
    localparam int NVEC = 29;
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b1, 12'h0A8, 32'h8010_0001, 4'd9},
        {1'b0, 12'h0A0, 32'h0177_0000, 4'd9},
        {1'b1, 12'h0A4, 32'h1234_5678, 4'd8},
        {1'b1, 12'h0A8, 32'hC010_0001, 4'd8},
        {1'b0, 12'h0AC, 32'h0000_0001, 4'd6},
        {1'b0, 12'h0A8, 32'h4010_0001, 4'd5},
        {1'b1, 12'h0A8, 32'h8010_0001, 4'd8},
        {1'b0, 12'h0A0, 32'h1234_5678, 4'd8},
        {1'b1, 12'h0A8, 32'h8010_0000, 4'd9},
        {1'b0, 12'h0A0, 32'h02FA_F080, 4'd9},
        {1'b1, 12'h0A8, 32'h8010_0002, 4'd9},
        {1'b0, 12'h0A0, 32'h017D_7840, 4'd9},
        {1'b1, 12'h0A8, 32'h8010_0003, 4'd7},
        {1'b0, 12'h0AC, 32'h0000_0003, 4'd7},
        {1'b0, 12'h0A0, 32'h017D_7840, 4'd7},
        {1'b1, 12'h0A8, 32'hC020_0000, 4'd7},
        {1'b0, 12'h0AC, 32'h0000_0003, 4'd7},
        {1'b1, 12'h0A8, 32'h8010_0000, 4'd7},
        {1'b0, 12'h0A0, 32'h02FA_F080, 4'd7},
        {1'b1, 12'h0A8, 32'h0010_0002, 4'd6},
        {1'b0, 12'h0AC, 32'h0000_0000, 4'd6},
        {1'b0, 12'h0A8, 32'h0010_0002, 4'd5},
        {1'b1, 12'h0A8, 32'hFFFF_FFFF, 4'd5},
        {1'b0, 12'h0A8, 32'h43F0_0FFF, 4'd5},
        {1'b0, 12'h0AC, 32'h0000_0003, 4'd7},
        {1'b1, 12'h0A4, 32'h0000_BEEF, 4'd8},
        {1'b1, 12'h0A8, 32'hC010_0002, 4'd8},
        {1'b1, 12'h0A8, 32'h8010_0002, 4'd8},
        {1'b0, 12'h0A0, 32'h0000_BEEF, 4'd8}
    };

    function automatic string req_name(input logic [3:0] code);
        case (code)
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
        #1 d = bus_rdata;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 led", {24'b0, led}, 32'h0);
        rd_check("R1 cfg0", 12'h000, 32'h0);
        rd_check("R1 cfg1", 12'h004, 32'h0);
        rd_check("R1 ret", 12'h0A0, 32'h0);
        rd_check("R1 out", 12'h0A4, 32'h0);
        rd_check("R1 ctrl", 12'h0A8, 32'h0010_0000);
        rd_check("R1 stat", 12'h0AC, 32'h0);
        rd_check("R1 lock", 12'h100, 32'hFFFF_0001);

        // Table walk: channel behaviour
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][48]) begin
                bus_wr(VEC[i][47:36], VEC[i][35:4]);
            end else begin
                rd_check(req_name(VEC[i][3:0]), VEC[i][47:36], VEC[i][35:4]);
            end
        end
        bus_idle();

        // R2 read/write words and LEDs
        bus_wr(12'h000, 32'hDEAD_BEEF);
        bus_wr(12'h004, 32'h0000_37A5);
        bus_idle();
        #1 check("R2 led", {24'b0, led}, 32'h0000_00A5);
        rd_check("R2 cfg0", 12'h000, 32'hDEAD_BEEF);
        rd_check("R2 cfg1", 12'h004, 32'h0000_37A5);
        rd_check("R2 out", 12'h0A4, 32'h0000_BEEF);

        // R3 read-only words ignore writes
        bus_wr(12'h00C, 32'hFFFF_FFFF);
        bus_wr(12'h010, 32'h1111_1111);
        bus_wr(12'hFF8, 32'h2222_2222);
        bus_wr(12'hFFC, 32'h3333_3333);
        rd_check("R3 cfg3", 12'h00C, 32'h0);
        rd_check("R3 cfg4", 12'h010, B_CFG4);
        rd_check("R3 aid", 12'hFF8, B_AID);
        rd_check("R3 id", 12'hFFC, B_ID);

        // R4 unmapped access
        bus_idle();
        rd_check("R4 unmapped read", 12'h200, 32'h0);
        @(posedge clk); #1 check("R4 err set", {31'b0, bus_err}, 32'h1);
        bus_idle();
        @(posedge clk); #1 check("R4 err clear", {31'b0, bus_err}, 32'h0);
        bus_wr(12'h004, 32'h0000_0000);
        @(posedge clk); #1 check("R4 err mapped", {31'b0, bus_err}, 32'h0);
        bus_wr(12'h0A2, 32'hFFFF_FFFF);
        bus_wr(12'h001, 32'hFFFF_FFFF);
        bus_idle();
        rd_check("R4 cfg0 kept", 12'h000, 32'hDEAD_BEEF);
        rd_check("R4 cfg1 kept", 12'h004, 32'h0);
        rd_check("R4 out kept", 12'h0A4, 32'h0000_BEEF);

        // R10 lock mask and summary
        loop_locked = 8'h00;
        bus_wr(12'h100, 32'h00FF_FFFF);
        rd_check("R10 zero mask", 12'h100, 32'h0000_0001);
        bus_wr(12'h100, 32'h0F00_0000);
        loop_locked = 8'h0F;
        rd_check("R10 masked all locked", 12'h100, 32'h0F0F_0001);
        loop_locked = 8'h07;
        rd_check("R10 unmasked flag low", 12'h100, 32'h0F07_0000);
        loop_locked = 8'hF7;
        rd_check("R10 masked-out set only", 12'h100, 32'h0FF7_0000);
        loop_locked = 8'h1F;
        rd_check("R10 extra flag set", 12'h100, 32'h0F1F_0001);
        bus_wr(12'h100, 32'hFFFF_FFFF);
        loop_locked = 8'hFE;
        rd_check("R10 full mask one low", 12'h100, 32'hFFFE_0000);
        bus_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule